// File: doc/BRIEF.md
# Strobed Parallel Host Bus Bridge

This block is the peripheral side of a narrow host link. A host drives a 16-bit shared data bus, a 3-bit command select, an active-low write strobe and an active-low read strobe. The block answers on a completion line and on an active-low interrupt-pending line. For a memory command the block builds a 24-bit address from two write strobes. The low half comes first and the upper byte second. A write command takes one more strobe for the data word. The block then issues a single word or byte request, with upper and lower byte enables, to a generic backend. On a read the block holds the returned word until the host takes it from the shared bus.

The strobes and the select lines are asynchronous to the block clock. They pass through a synchronizer, and the block acts on their edges. A status command needs no address phases. One write strobe loads the writable part of a 16-bit status word, and a read strobe returns that word. The top three bits of the status word always carry the backend's current interrupt level. The interrupt-pending output is low while that level is nonzero.

The backend request uses a valid/ready handshake. Once `be_req_valid` is high, it stays high and the address, data, write flag and lane enables stay constant until the cycle in which `be_req_ready` is high. The backend may hold `be_req_ready` low for as long as it needs. Only one request is ever outstanding. The response is a single-cycle `be_rsp_valid` pulse carrying `be_rdata`. It must come at least one cycle after the request was accepted, and it cannot be back-pressured.

Top module: `host_bus_bridge`

## Requirements
- R1: The select value `hb_sel` encodes the command: 3'b000 word write, 3'b001 word read, 3'b010 byte write, 3'b011 byte read, 3'b100 status access. Bit 0 set means read, bit 1 set means byte, and bit 2 set means status. The codes 3'b101, 3'b110 and 3'b111 start no request and leave `hb_ack` low.
- R2: In a memory command, the first rising edge of `hb_wr_n` captures address bits 15:0 from the bus. The second rising edge captures address bits 23:16 from bus bits 7:0.
- R3: In a write command, the third rising edge of `hb_wr_n` captures the write data. It also raises `be_req_valid` with `be_we`=1 and raises `hb_ack`. `hb_ack` falls in the cycle after the backend response.
- R4: In a read command, a falling `hb_read strobe` edge after the two address strobes raises `be_req_valid` with `be_we`=0. `hb_ack` stays low until the returned word is on `hb_data_o`, then goes high. It falls after `hb_rd_n` returns high.
- R5: `hb_data_oe` is high exactly while `hb_rd_n` is low.
- R6: A word access sets both `be_uds` and `be_lds`. A byte access with address bit 0 = 0 sets only `be_uds`, and with bit 0 = 1 sets only `be_lds`. A byte read returns the full 16-bit word.
- R7: While `be_req_valid` is high and `be_req_ready` is low, the request stays valid and its payload does not change.
- R8: A write strobe in the status command loads bus bits 12:0 into status bits 12:0. Bus bits 15:13 have no effect, and status bits 15:13 always show the interrupt level.
- R9: In the status command, a read strobe with no address phases returns the status word and raises `hb_ack`.
- R10: `be_ipl` is sampled each cycle into status bits 15:13. `hb_irq_n` is low one cycle after `be_ipl` becomes nonzero and high one cycle after it returns to zero.
- R11: A change of the select value clears the address phase counter, so the next write strobe is again taken as address bits 15:0.
- R12: After reset, `hb_ack` and `be_req_valid` are low, `hb_irq_n` is high and status bits 12:0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_sel | input | 3 | Command select from the host |
| hb_wr_n | input | 1 | Active-low write strobe; data is latched on its rising edge |
| hb_rd_n | input | 1 | Active-low read strobe |
| hb_data_i | input | 16 | Shared bus, value driven by the host |
| hb_data_o | output | 16 | Shared bus, value driven by the block |
| hb_data_oe | output | 1 | Output enable for `hb_data_o` |
| hb_ack | output | 1 | Completion line to the host |
| hb_irq_n | output | 1 | Active-low interrupt pending |
| be_req_valid | output | 1 | Backend request valid |
| be_req_ready | input | 1 | Backend accepts the request |
| be_addr | output | 24 | Request address |
| be_wdata | output | 16 | Request write data |
| be_we | output | 1 | 1 = write, 0 = read |
| be_uds | output | 1 | Upper byte lane enable |
| be_lds | output | 1 | Lower byte lane enable |
| be_rsp_valid | input | 1 | Single-cycle response strobe |
| be_rdata | input | 16 | Response read data |
| be_ipl | input | 3 | Backend interrupt level |

## Verification
The main path is driven from a vector table that mixes word and byte writes and reads. The table uses even and odd addresses and all-zero, all-one and mixed address patterns. This separates lane choice by address bit 0 from lane choice by command, and a swap of the two address halves shows up as a wrong address. Directed sequences then cover several cases:
- An unused select code.
- A select change between address strobes, which tells a cleared phase counter from a stale one.
- A backend that holds off `be_req_ready`, to test payload stability.
- A status write with ones in the level bits, to show those bits are ignored.
- Level changes that must reach both the status read and `hb_irq_n`.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
  localparam logic [2:0] CMD_WORD_WR = 3'b000;
  localparam logic [2:0] CMD_WORD_RD = 3'b001;
  localparam logic [2:0] CMD_BYTE_WR = 3'b010;
  localparam logic [2:0] CMD_BYTE_RD = 3'b011;
  localparam logic [2:0] CMD_STATUS  = 3'b100;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_ISSUE   = 2'd1,
    ST_AWAIT   = 2'd2,
    ST_PRESENT = 2'd3
  } hbb_state_e;
endpackage

// File: rtl/hbb_sync.sv
module hbb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] init_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= init_val;
        else        stage[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= init_val;
        else        stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hbb_status.sv
module hbb_status #(
  parameter int DATA_W = 16,
  parameter int IPL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IPL_W-1:0]  ipl,
  output logic [DATA_W-1:0] status_word,
  output logic              irq_n
);
  localparam int LOW_W = DATA_W - IPL_W;

  logic [IPL_W-1:0] level_q;
  logic [LOW_W-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      low_q   <= '0;
    end else begin
      level_q <= ipl;
      if (wr_en) low_q <= wr_data[LOW_W-1:0];
    end
  end

  assign status_word = {level_q, low_q};
  assign irq_n       = ~|level_q;

  // R10: a nonzero level asserts the pending line one cycle later
  assert_irq_follows_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl != '0) |=> !irq_n);
  // R8: a status write never disturbs the level field
  assert_level_unwritten_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (status_word[DATA_W-1:LOW_W] == $past(ipl)));
endmodule

// File: rtl/hbb_ctrl.sv
module hbb_ctrl
  import hbb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sel_s,
  input  logic              wr_n_s,
  input  logic              rd_n_s,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] status_word,
  output logic              status_wr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              req_we,
  output logic              req_uds,
  output logic              req_lds,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              ack,
  output logic [DATA_W-1:0] rd_word
);
  localparam int AHI_W = ADDR_W - DATA_W;

  hbb_state_e  state;
  logic [1:0]  phase;
  logic [2:0]  sel_q;
  logic        wr_q, rd_q;
  logic        wr_rise, rd_fall, rd_rise, sel_chg;
  logic        is_mem, is_read, is_byte, is_stat;

  assign wr_rise = wr_n_s & ~wr_q;
  assign rd_fall = ~rd_n_s & rd_q;
  assign rd_rise = rd_n_s & ~rd_q;
  assign sel_chg = (sel_s != sel_q);

  assign is_mem  = ~sel_s[2];
  assign is_read = sel_s[0];
  assign is_byte = sel_s[1];
  assign is_stat = (sel_s == CMD_STATUS);

  assign status_wr = (state == ST_COLLECT) && is_stat && wr_rise && !sel_chg;
  assign req_valid = (state == ST_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b1;
      rd_q  <= 1'b1;
      sel_q <= '0;
    end else begin
      wr_q  <= wr_n_s;
      rd_q  <= rd_n_s;
      sel_q <= sel_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_COLLECT;
      phase     <= '0;
      req_addr  <= '0;
      req_wdata <= '0;
      req_we    <= 1'b0;
      req_uds   <= 1'b0;
      req_lds   <= 1'b0;
      ack       <= 1'b0;
      rd_word   <= '0;
    end else begin
      unique case (state)
        ST_COLLECT: begin
          if (sel_chg) begin
            phase <= '0;
          end else if (is_mem && wr_rise) begin
            unique case (phase)
              2'd0: begin
                req_addr[DATA_W-1:0] <= data_i;
                phase <= 2'd1;
              end
              2'd1: begin
                req_addr[ADDR_W-1:DATA_W] <= data_i[AHI_W-1:0];
                phase <= 2'd2;
              end
              default: begin
                if (!is_read) begin
                  req_wdata <= data_i;
                  req_we    <= 1'b1;
                  req_uds   <= !is_byte || !req_addr[0];
                  req_lds   <= !is_byte ||  req_addr[0];
                  ack       <= 1'b1;
                  state     <= ST_ISSUE;
                end
              end
            endcase
          end else if (is_mem && is_read && rd_fall && phase == 2'd2) begin
            req_we  <= 1'b0;
            req_uds <= !is_byte || !req_addr[0];
            req_lds <= !is_byte ||  req_addr[0];
            state   <= ST_ISSUE;
          end else if (is_stat && rd_fall) begin
            rd_word <= status_word;
            ack     <= 1'b1;
            state   <= ST_PRESENT;
          end
        end
        ST_ISSUE: begin
          if (req_ready) state <= ST_AWAIT;
        end
        ST_AWAIT: begin
          if (rsp_valid) begin
            if (req_we) begin
              ack   <= 1'b0;
              phase <= '0;
              state <= ST_COLLECT;
            end else begin
              rd_word <= rsp_rdata;
              ack     <= 1'b1;
              state   <= ST_PRESENT;
            end
          end
        end
        default: begin
          if (rd_rise) begin
            ack   <= 1'b0;
            phase <= '0;
            state <= ST_COLLECT;
          end
        end
      endcase
    end
  end

  // R7: a stalled request keeps its payload
  assert_req_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_wdata)
                                   && $stable(req_we) && $stable(req_uds) && $stable(req_lds)));
  // R4: completion line stays low while a read is outstanding
  assert_read_ack_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |-> !ack);
  // R3: completion line drops after a write response
  assert_write_ack_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AWAIT && req_we && rsp_valid) |=> !ack);
  // R6: every request enables at least one lane
  assert_lane_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_uds || req_lds));
endmodule

// File: rtl/host_bus_bridge.sv
module host_bus_bridge #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 24,
  parameter int IPL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        hb_sel,
  input  logic              hb_wr_n,
  input  logic              hb_rd_n,
  input  logic [DATA_W-1:0] hb_data_i,
  output logic [DATA_W-1:0] hb_data_o,
  output logic              hb_data_oe,
  output logic              hb_ack,
  output logic              hb_irq_n,
  output logic              be_req_valid,
  input  logic              be_req_ready,
  output logic [ADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0] be_wdata,
  output logic              be_we,
  output logic              be_uds,
  output logic              be_lds,
  input  logic              be_rsp_valid,
  input  logic [DATA_W-1:0] be_rdata,
  input  logic [IPL_W-1:0]  be_ipl
);
  localparam int CTL_W = 5;

  logic [CTL_W-1:0]  ctl_sync;
  logic [DATA_W-1:0] status_word;
  logic              status_wr;

  hbb_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_val (5'b000_11),
    .d        ({hb_sel, hb_wr_n, hb_rd_n}),
    .q        (ctl_sync)
  );

  hbb_status #(.DATA_W(DATA_W), .IPL_W(IPL_W)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (status_wr),
    .wr_data     (hb_data_i),
    .ipl         (be_ipl),
    .status_word (status_word),
    .irq_n       (hb_irq_n)
  );

  hbb_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_s       (ctl_sync[4:2]),
    .wr_n_s      (ctl_sync[1]),
    .rd_n_s      (ctl_sync[0]),
    .data_i      (hb_data_i),
    .status_word (status_word),
    .status_wr   (status_wr),
    .req_valid   (be_req_valid),
    .req_ready   (be_req_ready),
    .req_addr    (be_addr),
    .req_wdata   (be_wdata),
    .req_we      (be_we),
    .req_uds     (be_uds),
    .req_lds     (be_lds),
    .rsp_valid   (be_rsp_valid),
    .rsp_rdata   (be_rdata),
    .ack         (hb_ack),
    .rd_word     (hb_data_o)
  );

  assign hb_data_oe = ~hb_rd_n;
endmodule

// File: tb/test_host_bus_bridge.sv
module test_host_bus_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  hb_sel = 3'b000;
  logic        hb_wr_n = 1'b1;
  logic        hb_rd_n = 1'b1;
  logic [15:0] hb_data_i = '0;
  logic [15:0] hb_data_o;
  logic        hb_data_oe, hb_ack, hb_irq_n;
  logic        be_req_valid;
  logic        be_req_ready = 1'b0;
  logic [23:0] be_addr;
  logic [15:0] be_wdata;
  logic        be_we, be_uds, be_lds;
  logic        be_rsp_valid = 1'b0;
  logic [15:0] be_rdata = '0;
  logic [2:0]  be_ipl = '0;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  host_bus_bridge i_host_bus_bridge (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_wr_n(hb_wr_n), .hb_rd_n(hb_rd_n),
    .hb_data_i(hb_data_i), .hb_data_o(hb_data_o), .hb_data_oe(hb_data_oe),
    .hb_ack(hb_ack), .hb_irq_n(hb_irq_n), .be_req_valid(be_req_valid),
    .be_req_ready(be_req_ready), .be_addr(be_addr), .be_wdata(be_wdata), .be_we(be_we),
    .be_uds(be_uds), .be_lds(be_lds), .be_rsp_valid(be_rsp_valid), .be_rdata(be_rdata),
    .be_ipl(be_ipl)
  );

  // backend model
  int          bp_wait = 2;
  int          stall_cnt = 0;
  int          rsp_cnt = 0;
  int          hs_count = 0;
  logic        seen = 1'b0;
  logic        stable_err = 1'b0;
  logic [23:0] first_addr = '0;
  logic [15:0] first_wdata = '0;
  logic [23:0] cap_addr = '0;
  logic [15:0] cap_wdata = '0;
  logic        cap_we = 1'b0, cap_uds = 1'b0, cap_lds = 1'b0;

  always @(posedge clk) begin
    be_req_ready <= 1'b0;
    be_rsp_valid <= 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt <= rsp_cnt - 1;
      if (rsp_cnt == 1) begin
        be_rsp_valid <= 1'b1;
        be_rdata     <= cap_addr[15:0] ^ 16'h5A3C;
      end
    end
    if (be_req_valid && !be_req_ready) begin
      if (!seen) begin
        seen        <= 1'b1;
        first_addr  <= be_addr;
        first_wdata <= be_wdata;
        stall_cnt   <= 1;
        if (bp_wait <= 0) be_req_ready <= 1'b1;
      end else begin
        if (be_addr != first_addr || be_wdata != first_wdata) stable_err <= 1'b1;
        stall_cnt <= stall_cnt + 1;
        if (stall_cnt >= bp_wait) be_req_ready <= 1'b1;
      end
    end
    if (be_req_valid && be_req_ready) begin
      cap_addr  <= be_addr;
      cap_wdata <= be_wdata;
      cap_we    <= be_we;
      cap_uds   <= be_uds;
      cap_lds   <= be_lds;
      hs_count  <= hs_count + 1;
      seen      <= 1'b0;
      rsp_cnt   <= 3;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [15:0] d);
    @(negedge clk) hb_data_i = d;
    hb_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    hb_wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_sel(input logic [2:0] v);
    @(negedge clk) hb_sel = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_ack(input logic v);
    for (int i = 0; i < 100; i++) begin
      if (hb_ack == v) break;
      @(negedge clk);
    end
  endtask

  task automatic read_strobe(output logic [15:0] word, output logic oe_seen,
                             output logic ack_early);
    @(negedge clk) hb_rd_n = 1'b0;
    @(negedge clk);
    oe_seen   = hb_data_oe;
    ack_early = hb_ack;
    wait_ack(1'b1);
    word = hb_data_o;
    hb_rd_n = 1'b1;
    wait_ack(1'b0);
    @(negedge clk);
  endtask

  // vectors: {cmd[2:0], addr[23:0], wdata[15:0]}
  localparam int NVEC = 8;
  localparam logic [42:0] VEC [NVEC] = '{
    {3'b000, 24'h123456, 16'hBEEF},
    {3'b001, 24'h00ABCE, 16'h0000},
    {3'b010, 24'h001000, 16'h7777},
    {3'b010, 24'h001001, 16'h0042},
    {3'b011, 24'hFF00FE, 16'h0000},
    {3'b011, 24'h7F0101, 16'h0000},
    {3'b000, 24'hFFFFFF, 16'h0000},
    {3'b001, 24'h000000, 16'h0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] word;
    logic        oe_seen, ack_early;
    int          hs_before;

    repeat (3) @(negedge clk);
    // R12: reset state
    check(hb_ack == 1'b0 && be_req_valid == 1'b0, "R12 ack/valid at reset",
          {hb_ack, be_req_valid}, 0);
    check(hb_irq_n == 1'b1, "R12 irq_n at reset", hb_irq_n, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(hb_data_oe == 1'b0, "R5 oe low while read strobe high", hb_data_oe, 0);

    // R12/R9: status after reset reads zero
    set_sel(3'b100);
    read_strobe(word, oe_seen, ack_early);
    check(word == 16'h0000, "R12 status reset value", word, 16'h0000);

    // vector walk: R1 R2 R3 R4 R5 R6
    for (int k = 0; k < NVEC; k++) begin
      logic [2:0]  cmd;
      logic [23:0] adr;
      logic [15:0] wd;
      logic        exp_uds, exp_lds, exp_we;
      logic [15:0] exp_rd;
      {cmd, adr, wd} = VEC[k];
      exp_we  = ~cmd[0];
      exp_uds = !cmd[1] || !adr[0];
      exp_lds = !cmd[1] ||  adr[0];
      exp_rd  = adr[15:0] ^ 16'h5A3C;
      set_sel(cmd);
      strobe(adr[15:0]);
      strobe({8'h00, adr[23:16]});
      if (exp_we) begin
        strobe(wd);
        check(hb_ack == 1'b1, "R3 ack rises after data strobe", hb_ack, 1);
        wait_ack(1'b0);
        check(cap_wdata == wd, "R3 write data", cap_wdata, wd);
      end else begin
        read_strobe(word, oe_seen, ack_early);
        check(oe_seen == 1'b1, "R5 oe high while read strobe low", oe_seen, 1);
        check(ack_early == 1'b0, "R4 ack low before read data", ack_early, 0);
        check(word == exp_rd, "R4 read word", word, exp_rd);
        check(hb_data_oe == 1'b0, "R5 oe low after read", hb_data_oe, 0);
        if (cmd[1]) begin
          if (adr[0]) check(word[7:0] == exp_rd[7:0], "R6 odd byte lane", word[7:0], exp_rd[7:0]);
          else        check(word[15:8] == exp_rd[15:8], "R6 even byte lane", word[15:8], exp_rd[15:8]);
        end
      end
      check(cap_addr == adr, "R2 captured address", cap_addr, adr);
      check(cap_we == exp_we, "R1 write flag from select", cap_we, exp_we);
      check({cap_uds, cap_lds} == {exp_uds, exp_lds}, "R6 byte enables",
            {cap_uds, cap_lds}, {exp_uds, exp_lds});
    end

    // R1: unused select code starts nothing
    hs_before = hs_count;
    set_sel(3'b110);
    strobe(16'h1234);
    strobe(16'h0056);
    strobe(16'h789A);
    @(negedge clk) hb_rd_n = 1'b0;
    repeat (12) @(negedge clk);
    check(hb_ack == 1'b0, "R1 unused code leaves ack low", hb_ack, 0);
    hb_rd_n = 1'b1;
    repeat (6) @(negedge clk);
    check(hs_count == hs_before, "R1 unused code issues no request", hs_count, hs_before);

    // R11: select change between address strobes clears the phase
    set_sel(3'b000);
    strobe(16'h1111);
    set_sel(3'b010);
    strobe(16'h0002);
    strobe(16'h0033);
    strobe(16'h5555);
    wait_ack(1'b0);
    check(cap_addr == 24'h330002, "R11 phase cleared on select change", cap_addr, 24'h330002);
    check({cap_uds, cap_lds} == 2'b10, "R11 lanes after restart", {cap_uds, cap_lds}, 2'b10);

    // R7: backend back-pressure
    bp_wait = 8;
    set_sel(3'b000);
    strobe(16'hC0DE);
    strobe(16'h00A5);
    strobe(16'hF00D);
    wait_ack(1'b0);
    check(stable_err == 1'b0, "R7 payload stable under stall", stable_err, 0);
    check(cap_addr == 24'hA5C0DE && cap_wdata == 16'hF00D, "R7 accepted payload",
          cap_addr, 24'hA5C0DE);
    bp_wait = 2;

    // R8/R9: status write ignores bits 15:13
    set_sel(3'b100);
    strobe(16'hFFFF);
    read_strobe(word, oe_seen, ack_early);
    check(word == 16'h1FFF, "R8 status write low field only", word, 16'h1FFF);
    check(oe_seen == 1'b1, "R9 status read drives bus", oe_seen, 1);

    // R10: level reaches irq_n and status
    @(negedge clk) be_ipl = 3'd5;
    @(negedge clk);
    check(hb_irq_n == 1'b0, "R10 irq_n low for nonzero level", hb_irq_n, 0);
    read_strobe(word, oe_seen, ack_early);
    check(word == 16'hBFFF, "R10 level in status bits 15:13", word, 16'hBFFF);
    strobe(16'h0000);
    read_strobe(word, oe_seen, ack_early);
    check(word == 16'hA000, "R8 level kept across status write", word, 16'hA000);
    @(negedge clk) be_ipl = 3'd0;
    @(negedge clk);
    check(hb_irq_n == 1'b1, "R10 irq_n high for zero level", hb_irq_n, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule